// File: doc/BRIEF.md
# Fast System-Call Entry Unit

This unit computes the architectural state that a processor takes on when software issues its fast operating-system entry. It holds a small set of model-specific configuration registers: a feature-enable register, a combined selector/legacy-target register, one target register for 64-bit callers, one for compatibility callers, and a flag-mask register. A write port loads them. A one-cycle call strobe, together with the caller's mode, flags and next-instruction pointer, produces the return pointer to save, the flag image to save, the entry pointer, the code and stack selectors, the flat segment shapes, the masked flags and the new privilege level. All of these results arrive one cycle after the strobe.

If the feature is switched off, or if the capability input reports it as unsupported, the call is refused. The unit then raises an invalid-opcode fault and leaves every state output as it was. The write port refuses a long-mode target address that is not canonical and raises a general-protection fault for it.

Top module: `fastcall_entry`

## Requirements
- R1: After reset every output is zero, except `newCpl`, which resets to 3 (user level).
- R2: A call made while bit 0 of register 0xC000_0080 is 0, or while `featureOk` is 0, gives `done`=1 and `udFault`=1 one cycle later. Both write strobes stay low and every state output keeps its previous value.
- R3: The entry pointer depends on `callMode`. Mode 2'b10 (64-bit) takes register 0xC000_0082. Mode 2'b01 (compatibility) takes register 0xC000_0083. Modes 2'b00 and 2'b11 (legacy) take bits 31:0 of register 0xC000_0081, zero-extended.
- R4: `csSel` is bits 47:32 of register 0xC000_0081 with bits 1:0 forced to 0. `ssSel` is `csSel` plus 8, wrapping modulo 2^16.
- R5: An accepted call drives both bases to 0 and both limits to 0xFFFFFFFF. `csIs64` and `ssIs64` are set to 1 in the two long modes and to 0 in legacy mode.
- R6: In the long modes an accepted call sets `retPtr` to `nextIp`, and sets `flagSave` to `curFlags` with bit 16 (RF) cleared, with both write strobes high. In legacy mode `retPtr` is the zero-extended low 32 bits of `nextIp`, and only `retPtrWr` is high, so `flagSave` holds its previous value.
- R7: In the long modes `newFlags` is `curFlags` ANDed with the complement of the low 32 bits of register 0xC000_0084, and then bit 16 is cleared. The upper 32 bits of that register have no effect.
- R8: In legacy mode `newFlags` is the low 32 bits of `curFlags` with bits 17 (VM), 16 (RF) and 9 (IF) cleared, and upper bits zero.
- R9: An accepted call sets `newCpl` to 0. No privilege or mode check is made.
- R10: A write of a value whose bits 63:47 are not all equal, to 0xC000_0082 or 0xC000_0083, gives a one-cycle `gpFault` the next cycle and leaves the register unchanged. No other write raises `gpFault`.
- R11: `done` is high exactly in the cycle after each `callReq` cycle, and low in every other cycle.
- R12: A write to any address other than 0xC000_0080 to 0xC000_0084 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgAddr | input | 32 | Configuration register address |
| cfgWrData | input | 64 | Configuration write data |
| gpFault | output | 1 | Rejected non-canonical target write (one cycle) |
| featureOk | input | 1 | Capability: fast entry supported |
| callReq | input | 1 | Fast-entry call strobe |
| callMode | input | 2 | Caller mode: 00 legacy, 01 compatibility, 10 64-bit, 11 legacy |
| curFlags | input | 64 | Caller flag register |
| nextIp | input | 64 | Address of the following instruction |
| done | output | 1 | Call result valid |
| udFault | output | 1 | Call refused, invalid opcode |
| retPtrWr | output | 1 | Write strobe for saved return pointer |
| retPtr | output | 64 | Saved return pointer |
| flagSaveWr | output | 1 | Write strobe for saved flag image |
| flagSave | output | 64 | Saved flag image |
| newIp | output | 64 | Entry instruction pointer |
| newFlags | output | 64 | Flags after masking |
| csSel | output | 16 | New code selector |
| ssSel | output | 16 | New stack selector |
| csBase | output | 32 | Code segment base |
| ssBase | output | 32 | Stack segment base |
| csLimit | output | 32 | Code segment limit |
| ssLimit | output | 32 | Stack segment limit |
| csIs64 | output | 1 | Code segment is 64-bit |
| ssIs64 | output | 1 | Stack is 64-bit |
| newCpl | output | 2 | New privilege level |

## Verification
The properties assume that `callMode`, `cfgAddr` and the data inputs are free of unknowns whenever their strobes are high. They also assume that a configuration write and a call never fall in the same cycle, because the unit leaves that order to the surrounding pipeline. The stimulus keeps these assumptions by driving every input at the falling edge and keeping each strobe high for exactly one cycle. Calls and writes go in separate cycles, and all four mode codes are exercised.

// File: rtl/fastcall_pkg.sv
package fastcall_pkg;

  localparam int unsigned REG_ADDR_W = 32;
  localparam logic [REG_ADDR_W-1:0] ADDR_FEAT  = 32'hC000_0080;
  localparam logic [REG_ADDR_W-1:0] ADDR_SEL   = 32'hC000_0081;
  localparam logic [REG_ADDR_W-1:0] ADDR_LTGT  = 32'hC000_0082;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTGT  = 32'hC000_0083;
  localparam logic [REG_ADDR_W-1:0] ADDR_FMASK = 32'hC000_0084;

  localparam int unsigned BIT_IF = 9;
  localparam int unsigned BIT_RF = 16;
  localparam int unsigned BIT_VM = 17;

  typedef enum logic [1:0] {
    MODE_LEGACY = 2'b00,
    MODE_COMPAT = 2'b01,
    MODE_64     = 2'b10,
    MODE_ALT    = 2'b11
  } callMode_e;

  typedef struct packed {
    logic accept;
    logic refuse;
    logic longMode;
    logic compat;
    logic wrFeat;
    logic wrSel;
    logic wrLtgt;
    logic wrCtgt;
    logic wrMask;
  } stepCtl_t;

  function automatic logic isCanonical(input logic [63:0] va, input int unsigned vaBits);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i >= int'(vaBits) - 1 && va[i] != va[63]) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/fastcall_ctrl.sv
module fastcall_ctrl
  import fastcall_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic [1:0]        callMode,
  input  logic              featureOk,
  input  logic              sceBit,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output stepCtl_t          ctl,
  output logic              done,
  output logic              gpFault
);

  logic hitFeat, hitSel, hitLtgt, hitCtgt, hitMask;
  logic dataCanon, rejectWr, enabled;
  callMode_e modeE;

  assign modeE     = callMode_e'(callMode);
  assign enabled   = featureOk & sceBit;
  assign dataCanon = isCanonical(64'(cfgWrData), VA_BITS);

  assign hitFeat = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_FEAT));
  assign hitSel  = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_SEL));
  assign hitLtgt = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_LTGT));
  assign hitCtgt = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_CTGT));
  assign hitMask = cfgWrEn && (cfgAddr == ADDR_W'(ADDR_FMASK));
  assign rejectWr = (hitLtgt || hitCtgt) && !dataCanon;

  always_comb begin
    ctl          = '0;
    ctl.accept   = callReq && enabled;
    ctl.refuse   = callReq && !enabled;
    ctl.longMode = (modeE == MODE_64) || (modeE == MODE_COMPAT);
    ctl.compat   = (modeE == MODE_COMPAT);
    ctl.wrFeat   = hitFeat;
    ctl.wrSel    = hitSel;
    ctl.wrLtgt   = hitLtgt && dataCanon;
    ctl.wrCtgt   = hitCtgt && dataCanon;
    ctl.wrMask   = hitMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      gpFault <= 1'b0;
    end else begin
      done    <= callReq;
      gpFault <= rejectWr;
    end
  end

endmodule

// File: rtl/fastcall_dp.sv
module fastcall_dp
  import fastcall_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned SEG_W  = 32,
  parameter int unsigned MASK_W = 32,
  parameter int unsigned LEG_W  = 32,
  parameter int unsigned SEL_LO = 32,
  parameter int unsigned SS_OFS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic [DATA_W-1:0] curFlags,
  input  logic [DATA_W-1:0] nextIp,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              sceBit,
  output logic              udFault,
  output logic              retPtrWr,
  output logic [DATA_W-1:0] retPtr,
  output logic              flagSaveWr,
  output logic [DATA_W-1:0] flagSave,
  output logic [DATA_W-1:0] newIp,
  output logic [DATA_W-1:0] newFlags,
  output logic [SEL_W-1:0]  csSel,
  output logic [SEL_W-1:0]  ssSel,
  output logic [SEG_W-1:0]  csBase,
  output logic [SEG_W-1:0]  ssBase,
  output logic [SEG_W-1:0]  csLimit,
  output logic [SEG_W-1:0]  ssLimit,
  output logic              csIs64,
  output logic              ssIs64,
  output logic [1:0]        newCpl
);

  localparam int unsigned SEL_HI  = SEL_LO + SEL_W - 1;
  localparam logic [DATA_W-1:0] RF_MASK  = DATA_W'(1) << BIT_RF;
  localparam logic [DATA_W-1:0] LEG_CLR  = (DATA_W'(1) << BIT_RF) |
                                           (DATA_W'(1) << BIT_VM) |
                                           (DATA_W'(1) << BIT_IF);
  localparam logic [SEL_W-1:0] RPL_CLR   = ~SEL_W'(3);

  logic [DATA_W-1:0] selReg, ltgtReg, ctgtReg;
  logic [MASK_W-1:0] maskReg;

  logic [DATA_W-1:0] nxtTarget, nxtRet, nxtFlags, flagsNoRf, legFlags;
  logic [SEL_W-1:0]  nxtCsSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sceBit  <= 1'b0;
      selReg  <= '0;
      ltgtReg <= '0;
      ctgtReg <= '0;
      maskReg <= '0;
    end else begin
      if (ctl.wrFeat) sceBit  <= cfgWrData[0];
      if (ctl.wrSel)  selReg  <= cfgWrData;
      if (ctl.wrLtgt) ltgtReg <= cfgWrData;
      if (ctl.wrCtgt) ctgtReg <= cfgWrData;
      if (ctl.wrMask) maskReg <= cfgWrData[MASK_W-1:0];
    end
  end

  assign flagsNoRf = curFlags & ~RF_MASK;
  assign legFlags  = {{(DATA_W-LEG_W){1'b0}}, curFlags[LEG_W-1:0]} & ~LEG_CLR;
  assign nxtCsSel  = selReg[SEL_HI:SEL_LO] & RPL_CLR;

  always_comb begin
    if (ctl.longMode) begin
      nxtTarget = ctl.compat ? ctgtReg : ltgtReg;
      nxtRet    = nextIp;
      nxtFlags  = flagsNoRf & ~{{(DATA_W-MASK_W){1'b0}}, maskReg};
    end else begin
      nxtTarget = {{(DATA_W-LEG_W){1'b0}}, selReg[LEG_W-1:0]};
      nxtRet    = {{(DATA_W-LEG_W){1'b0}}, nextIp[LEG_W-1:0]};
      nxtFlags  = legFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      udFault    <= 1'b0;
      retPtrWr   <= 1'b0;
      flagSaveWr <= 1'b0;
    end else begin
      udFault    <= ctl.refuse;
      retPtrWr   <= ctl.accept;
      flagSaveWr <= ctl.accept && ctl.longMode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retPtr   <= '0;
      flagSave <= '0;
      newIp    <= '0;
      newFlags <= '0;
      csSel    <= '0;
      ssSel    <= '0;
      csBase   <= '0;
      ssBase   <= '0;
      csLimit  <= '0;
      ssLimit  <= '0;
      csIs64   <= 1'b0;
      ssIs64   <= 1'b0;
      newCpl   <= 2'b11;
    end else if (ctl.accept) begin
      retPtr   <= nxtRet;
      if (ctl.longMode) flagSave <= flagsNoRf;
      newIp    <= nxtTarget;
      newFlags <= nxtFlags;
      csSel    <= nxtCsSel;
      ssSel    <= nxtCsSel + SEL_W'(SS_OFS);
      csBase   <= '0;
      ssBase   <= '0;
      csLimit  <= '1;
      ssLimit  <= '1;
      csIs64   <= ctl.longMode;
      ssIs64   <= ctl.longMode;
      newCpl   <= 2'b00;
    end
  end

endmodule

// File: rtl/fastcall_entry.sv
module fastcall_entry
  import fastcall_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VA_BITS = 48,
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned SEG_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              gpFault,
  input  logic              featureOk,
  input  logic              callReq,
  input  logic [1:0]        callMode,
  input  logic [DATA_W-1:0] curFlags,
  input  logic [DATA_W-1:0] nextIp,
  output logic              done,
  output logic              udFault,
  output logic              retPtrWr,
  output logic [DATA_W-1:0] retPtr,
  output logic              flagSaveWr,
  output logic [DATA_W-1:0] flagSave,
  output logic [DATA_W-1:0] newIp,
  output logic [DATA_W-1:0] newFlags,
  output logic [SEL_W-1:0]  csSel,
  output logic [SEL_W-1:0]  ssSel,
  output logic [SEG_W-1:0]  csBase,
  output logic [SEG_W-1:0]  ssBase,
  output logic [SEG_W-1:0]  csLimit,
  output logic [SEG_W-1:0]  ssLimit,
  output logic              csIs64,
  output logic              ssIs64,
  output logic [1:0]        newCpl
);

  stepCtl_t ctl;
  logic     sceBit;

  fastcall_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VA_BITS(VA_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .callReq  (callReq),
    .callMode (callMode),
    .featureOk(featureOk),
    .sceBit   (sceBit),
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .ctl      (ctl),
    .done     (done),
    .gpFault  (gpFault)
  );

  fastcall_dp #(
    .DATA_W(DATA_W),
    .SEL_W (SEL_W),
    .SEG_W (SEG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .curFlags  (curFlags),
    .nextIp    (nextIp),
    .cfgWrData (cfgWrData),
    .sceBit    (sceBit),
    .udFault   (udFault),
    .retPtrWr  (retPtrWr),
    .retPtr    (retPtr),
    .flagSaveWr(flagSaveWr),
    .flagSave  (flagSave),
    .newIp     (newIp),
    .newFlags  (newFlags),
    .csSel     (csSel),
    .ssSel     (ssSel),
    .csBase    (csBase),
    .ssBase    (ssBase),
    .csLimit   (csLimit),
    .ssLimit   (ssLimit),
    .csIs64    (csIs64),
    .ssIs64    (ssIs64),
    .newCpl    (newCpl)
  );

endmodule

// File: rtl/fastcall_entry_chk.sv
module fastcall_entry_chk
  import fastcall_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [31:0] cfgAddr,
  input logic [63:0] cfgWrData,
  input logic        gpFault,
  input logic        callReq,
  input logic        done,
  input logic        udFault,
  input logic        retPtrWr,
  input logic        flagSaveWr,
  input logic [63:0] newIp,
  input logic [63:0] newFlags,
  input logic [15:0] csSel,
  input logic [15:0] ssSel,
  input logic [31:0] csBase,
  input logic [31:0] ssBase,
  input logic [31:0] csLimit,
  input logic [31:0] ssLimit,
  input logic [1:0]  newCpl
);

  p_refuse_holds_r2: assert property (@(posedge clk) disable iff (!rstN)
    udFault |-> $stable(newIp) && $stable(csSel) && !retPtrWr && !flagSaveWr);

  p_ss_after_cs_r4: assert property (@(posedge clk) disable iff (!rstN)
    retPtrWr |-> ssSel == csSel + 16'd8);

  p_flat_segs_r5: assert property (@(posedge clk) disable iff (!rstN)
    retPtrWr |-> (csBase == '0) && (ssBase == '0) && (&csLimit) && (&ssLimit));

  p_save_long_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    flagSaveWr |-> retPtrWr);

  p_rf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    retPtrWr |-> !newFlags[BIT_RF]);

  p_cpl_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    retPtrWr |-> newCpl == 2'b00);

  p_gp_on_bad_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && (cfgAddr == ADDR_LTGT || cfgAddr == ADDR_CTGT) && !isCanonical(cfgWrData, 48)
    |=> gpFault);

  p_done_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    callReq |=> done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !callReq |=> !done && !udFault && !retPtrWr);

  p_ud_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(udFault && retPtrWr));

endmodule

bind fastcall_entry fastcall_entry_chk u_chk (.*);

// File: tb/fastcall_entry_bench.sv
module fastcall_entry_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgAddr = '0;
  logic [63:0] cfgWrData = '0;
  logic        gpFault;
  logic        featureOk = 1'b1;
  logic        callReq = 1'b0;
  logic [1:0]  callMode = 2'b00;
  logic [63:0] curFlags = '0;
  logic [63:0] nextIp = '0;
  logic        done, udFault, retPtrWr, flagSaveWr, csIs64, ssIs64;
  logic [63:0] retPtr, flagSave, newIp, newFlags;
  logic [15:0] csSel, ssSel;
  logic [31:0] csBase, ssBase, csLimit, ssLimit;
  logic [1:0]  newCpl;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  localparam logic [63:0] SEL_V   = 64'h0000_ABCD_1234_5678;
  localparam logic [63:0] LTGT_V  = 64'hFFFF_8000_0010_0000;
  localparam logic [63:0] CTGT_V  = 64'h0000_7FFF_FFFF_0000;
  localparam logic [63:0] MASK_V  = 64'hDEAD_0000_0004_0700;

  always #10 clk = ~clk;

  fastcall_entry u_fastcall_entry (.*);

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      summary();
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [31:0] a, logic [63:0] d, logic expGp);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    chk("R10", "gpFault after write", 64'(gpFault), 64'(expGp));
    @(negedge clk);
    chk("R10", "gpFault one cycle", 64'(gpFault), 64'd0);
  endtask

  task automatic doCall(logic [1:0] m, logic [63:0] f, logic [63:0] ip);
    @(negedge clk);
    callReq = 1'b1; callMode = m; curFlags = f; nextIp = ip;
    @(negedge clk);
    callReq = 1'b0;
    chk("R11", "done after call", 64'(done), 64'd1);
  endtask

  function automatic logic [63:0] longFlags(logic [63:0] f, logic [63:0] mask);
    return f & ~{32'h0, mask[31:0]} & ~(64'h1 << 16);
  endfunction

  function automatic logic [63:0] legFlags(logic [63:0] f);
    return {32'h0, f[31:0]} & ~((64'h1 << 17) | (64'h1 << 16) | (64'h1 << 9));
  endfunction

  task automatic t_reset();
    chk("R1", "done", 64'(done), 0);
    chk("R1", "newIp", newIp, 0);
    chk("R1", "csSel", 64'(csSel), 0);
    chk("R1", "csLimit", 64'(csLimit), 0);
    chk("R1", "newCpl", 64'(newCpl), 3);
    chk("R1", "gpFault", 64'(gpFault), 0);
  endtask

  task automatic t_refuse(string why);
    logic [63:0] ipBefore, flBefore;
    ipBefore = newIp; flBefore = newFlags;
    doCall(2'b10, 64'h0000_0000_0003_0246, 64'h0000_0000_0040_1000);
    chk("R2", {why, " udFault"}, 64'(udFault), 1);
    chk("R2", {why, " retPtrWr"}, 64'(retPtrWr), 0);
    chk("R2", {why, " flagSaveWr"}, 64'(flagSaveWr), 0);
    chk("R2", {why, " newIp held"}, newIp, ipBefore);
    chk("R2", {why, " newFlags held"}, newFlags, flBefore);
    @(negedge clk);
    chk("R11", "done low after", 64'(done), 0);
  endtask

  task automatic t_call64();
    logic [63:0] f;
    f = 64'h0000_0001_0005_0746;
    doCall(2'b10, f, 64'h0000_7000_0000_1234);
    chk("R2", "udFault low", 64'(udFault), 0);
    chk("R3", "64-bit target", newIp, LTGT_V);
    chk("R4", "csSel", 64'(csSel), 64'h0000_ABCC);
    chk("R4", "ssSel", 64'(ssSel), 64'h0000_ABD4);
    chk("R5", "csBase", 64'(csBase), 0);
    chk("R5", "ssLimit", 64'(ssLimit), 64'hFFFF_FFFF);
    chk("R5", "csIs64", 64'(csIs64), 1);
    chk("R5", "ssIs64", 64'(ssIs64), 1);
    chk("R6", "retPtr", retPtr, 64'h0000_7000_0000_1234);
    chk("R6", "flagSave", flagSave, f & ~(64'h1 << 16));
    chk("R6", "flagSaveWr", 64'(flagSaveWr), 1);
    chk("R7", "newFlags masked", newFlags, longFlags(f, MASK_V));
    chk("R9", "newCpl", 64'(newCpl), 0);
  endtask

  task automatic t_callCompat();
    logic [63:0] f;
    f = 64'h0000_0000_0002_0202;
    doCall(2'b01, f, 64'h0000_0000_8000_0010);
    chk("R3", "compat target", newIp, CTGT_V);
    chk("R5", "csIs64 compat", 64'(csIs64), 1);
    chk("R6", "retPtr compat", retPtr, 64'h0000_0000_8000_0010);
    chk("R7", "newFlags compat", newFlags, longFlags(f, MASK_V));
  endtask

  task automatic t_callLegacy(logic [1:0] m);
    logic [63:0] f, savedBefore;
    f = 64'hFFFF_0000_0003_0347;
    savedBefore = flagSave;
    doCall(m, f, 64'h1111_2222_3333_4444);
    chk("R3", "legacy target", newIp, {32'h0, SEL_V[31:0]});
    chk("R5", "csIs64 legacy", 64'(csIs64), 0);
    chk("R5", "ssIs64 legacy", 64'(ssIs64), 0);
    chk("R6", "retPtr legacy", retPtr, 64'h0000_0000_3333_4444);
    chk("R6", "flagSaveWr legacy", 64'(flagSaveWr), 0);
    chk("R6", "flagSave held", flagSave, savedBefore);
    chk("R8", "legacy flags", newFlags, legFlags(f));
    chk("R9", "newCpl legacy", 64'(newCpl), 0);
  endtask

  task automatic t_badTargets();
    cfgWrite(32'hC000_0082, 64'h0000_8000_0000_0000, 1'b1);
    cfgWrite(32'hC000_0083, 64'h1234_0000_0000_0000, 1'b1);
    doCall(2'b10, 64'h2, 64'h10);
    chk("R10", "ltgt unchanged", newIp, LTGT_V);
    doCall(2'b01, 64'h2, 64'h10);
    chk("R10", "ctgt unchanged", newIp, CTGT_V);
  endtask

  task automatic t_unmapped();
    cfgWrite(32'hC000_0085, 64'h0000_0000_0000_0000, 1'b0);
    cfgWrite(32'hC000_0180, 64'h0000_0000_0000_0000, 1'b0);
    doCall(2'b10, 64'h0000_0000_0000_0702, 64'h20);
    chk("R12", "target unchanged", newIp, LTGT_V);
    chk("R12", "mask unchanged", newFlags, 64'h0000_0000_0000_0002);
  endtask

  task automatic t_selWrap();
    cfgWrite(32'hC000_0081, 64'h8000_FFFF_0000_1000, 1'b0);
    doCall(2'b00, 64'h0, 64'h0);
    chk("R4", "csSel rpl cleared", 64'(csSel), 64'h0000_FFFC);
    chk("R4", "ssSel wraps", 64'(ssSel), 64'h0000_0004);
    chk("R3", "legacy low half", newIp, 64'h0000_0000_0000_1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_refuse("feature bit off");
    cfgWrite(32'hC000_0080, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    t_refuse("bit0 zero");
    cfgWrite(32'hC000_0080, 64'h1, 1'b0);
    cfgWrite(32'hC000_0081, SEL_V, 1'b0);
    cfgWrite(32'hC000_0082, LTGT_V, 1'b0);
    cfgWrite(32'hC000_0083, CTGT_V, 1'b0);
    cfgWrite(32'hC000_0084, MASK_V, 1'b0);
    t_call64();
    t_callCompat();
    t_callLegacy(2'b00);
    t_callLegacy(2'b11);
    featureOk = 1'b0;
    t_refuse("unsupported");
    featureOk = 1'b1;
    t_badTargets();
    t_unmapped();
    t_selWrap();
    @(negedge clk);
    chk("R11", "done idle", 64'(done), 0);
    summary();
  end

endmodule